// File: doc/BRIEF.md
# Byte-Wide SPI Port with Buffered Status

This block is a byte-wide SPI serial port that works as bus master or bus slave. Software never sees the shift register itself. Everything goes through one buffer register. Writing the buffer loads the outgoing byte, and in master mode that write also starts an exchange. After a full byte has been exchanged, the received byte is placed in the buffer, a buffer-full flag rises and a one-cycle completion interrupt fires. Software therefore does not need to poll.

Reading the buffer clears the buffer-full flag. A write that arrives while a byte is still being shifted is refused and recorded in a sticky collision flag. If a byte completes while the previous one is still unread, the old byte is kept and a sticky overflow flag is raised. Dropping the enable input holds the whole port in reset, so it can be reconfigured before it is enabled again.

The serial mode is fixed. Bits go out MSB first and SCK idles low. SDI is sampled on the rising SCK edge and SDO changes on the falling edge. In master mode SCK is the system clock divided by `CLK_DIV`. In slave mode SCK and the active-low select are inputs, passed through synchronizers before use.

Top module: `spi_byte_port`

## Requirements
- R1: In master mode, a buffer write while no byte is in flight loads the shift register and starts an exchange. The written byte appears on `sdo` MSB first, one bit per SCK period. `sck_out` idles low, `sdo` changes only on falling SCK edges and `sdi` is sampled at each rising SCK edge.
- R2: In master mode, SCK runs at the system clock divided by `CLK_DIV`. `done_irq` is high in the cycle that follows the `DATA_W*CLK_DIV`-th rising clock edge after the edge that samples the write (32 with the defaults).
- R3: At the end of a byte, if `buf_full` was clear or is being read in that cycle, the received byte (first received bit in bit 7) is copied to `rd_data` and `buf_full` is set. `done_irq` is high for exactly one cycle for every completed byte.
- R4: A cycle with `rd_en` high clears `buf_full` at the next edge, unless a byte completes on that same edge. `rd_data` always shows the buffer.
- R5: A buffer write while a byte is in flight sets the sticky `wcol` flag. The write is not loaded, so the byte on `sdo` is unchanged.
- R6: A byte that completes while `buf_full` is set and not being read sets the sticky `ovfl` flag. It leaves `rd_data` and `buf_full` unchanged.
- R7: While `enable` is low, the port is held in reset. `buf_full`, `wcol`, `ovfl`, `done_irq`, `sck_out` and `sdo_en` are all 0, and buffer writes are ignored. This is also the state after `rst_n`.
- R8: In slave mode, with `ss_n_in` low, the port shifts on the synchronized `sck_in` edges using the same bit order and edges as master mode. It receives the byte from `sdi` into the buffer, sends the loaded byte on `sdo` and drives `sdo_en` high.
- R9: In slave mode, `ss_n_in` high discards any partial byte and clears the bit count, so no completion is reported. `sdo_en` goes low two clocks after the select is seen high. A later full byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low holds the port in reset |
| master | input | 1 | 1 = master (drives SCK), 0 = slave |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Buffer read strobe; clears buffer-full |
| rd_data | output | DATA_W | Buffer contents (last received byte) |
| buf_full | output | 1 | Received byte waiting in the buffer |
| wcol | output | 1 | Sticky write-collision flag |
| ovfl | output | 1 | Sticky receive-overflow flag |
| done_irq | output | 1 | One-cycle completion pulse |
| sck_in | input | 1 | Serial clock from an external master (slave mode) |
| ss_n_in | input | 1 | Active-low slave select (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for SDO; low means high impedance |

## Verification
The bench builds the port with its defaults: `DATA_W` = 8 and `CLK_DIV` = 4. With these values the predicted master latency is exactly 32 cycles, so that check can be exact. Slave-mode SCK is driven with a half-period of six system clocks. This is slow enough for the two-stage synchronizer to see every edge, and it lets SDO settle before the bench samples it on the rising edge. Eight-bit bytes also make the MSB-first order visible with asymmetric patterns such as 0x01 against 0x80. They also make an abort after three bits clearly different from a complete byte.

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              master,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              wcol,
  output logic              ovfl,
  output logic              done_irq,
  input  logic              sck_in,
  input  logic              ss_n_in,
  output logic              sck_out,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg, bufr;
  logic [CNT_W-1:0]  bits;
  logic [DIV_W-1:0]  div;
  logic              busy, sck_q, rx_bit;
  logic [2:0]        sck_s;
  logic [1:0]        ss_s;

  wire ss_act  = ~ss_s[1];
  wire active  = busy | (bits != '0);
  wire tick    = busy && (div == DIV_W'(HALF - 1));
  wire rise    = master ? (tick & ~sck_q) : (ss_act & sck_s[1] & ~sck_s[2]);
  wire fall    = master ? (tick & sck_q)  : (ss_act & ~sck_s[1] & sck_s[2]);
  wire last    = fall && (bits == CNT_W'(DATA_W));
  wire load    = wr_en & ~active;
  wire keep    = buf_full & ~rd_en;
  wire [DATA_W-1:0] rx_word = {shreg[DATA_W-2:0], rx_bit};

  assign rd_data = bufr;
  assign sck_out = sck_q;
  assign sdo     = shreg[DATA_W-1];
  assign sdo_en  = enable & (master | ss_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      ss_s  <= '1;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      ss_s  <= {ss_s[0], ss_n_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bufr <= '0; bits <= '0; div <= '0;
      busy <= 1'b0; sck_q <= 1'b0; rx_bit <= 1'b0;
      buf_full <= 1'b0; wcol <= 1'b0; ovfl <= 1'b0; done_irq <= 1'b0;
    end else if (!enable) begin
      shreg <= '0; bufr <= '0; bits <= '0; div <= '0;
      busy <= 1'b0; sck_q <= 1'b0; rx_bit <= 1'b0;
      buf_full <= 1'b0; wcol <= 1'b0; ovfl <= 1'b0; done_irq <= 1'b0;
    end else begin
      done_irq <= last;
      if (wr_en && active) wcol <= 1'b1;
      if (busy) div <= tick ? '0 : div + 1'b1;
      if (tick) sck_q <= ~sck_q;

      if (!master && !ss_act) begin
        bits <= '0;
      end else if (rise) begin
        rx_bit <= sdi;
        bits   <= bits + 1'b1;
      end else if (fall) begin
        shreg <= rx_word;
        if (last) bits <= '0;
      end

      if (last) busy <= 1'b0;
      if (load) begin
        shreg <= wr_data;
        busy  <= master;
        div   <= '0;
      end

      if (last) begin
        if (keep) ovfl <= 1'b1;
        else begin
          bufr     <= rx_word;
          buf_full <= 1'b1;
        end
      end else if (rd_en) begin
        buf_full <= 1'b0;
      end
    end
  end
endmodule

module spi_byte_port_chk #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              master,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              buf_full,
  input logic              wcol,
  input logic              ovfl,
  input logic              done_irq,
  input logic              sck_in,
  input logic              ss_n_in,
  input logic              sck_out,
  input logic              sdi,
  input logic              sdo,
  input logic              sdo_en
);
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && enable |=> !buf_full || done_irq); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R3
  AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> buf_full); // R3
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !rd_en && enable |=> !done_irq || (ovfl && $stable(rd_data))); // R6
  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !buf_full && !wcol && !ovfl && !sck_out && !done_irq); // R7
  AST_SLAVE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && ss_n_in) ##1 (!master && ss_n_in) ##1 (!master && ss_n_in) |-> !sdo_en); // R9
  AST_WCOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(wr_en)); // R5
endmodule

bind spi_byte_port spi_byte_port_chk #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_chk (.*);

// File: tb/spi_byte_port_bench.sv
module spi_byte_port_bench;
  logic       clk = 1'b0;
  logic       rst_n, enable, master, wr_en, rd_en, sck_in, ss_n_in, sdi;
  logic [7:0] wr_data, rd_data;
  logic       buf_full, wcol, ovfl, done_irq, sck_out, sdo, sdo_en;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_e;

  always #10 clk = ~clk;

  spi_byte_port u_spi_byte_port (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .buf_full(buf_full), .wcol(wcol), .ovfl(ovfl), .done_irq(done_irq),
    .sck_in(sck_in), .ss_n_in(ss_n_in), .sck_out(sck_out),
    .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: scoreboard pops one expected buffer value per completion (R3)
  always @(negedge clk) begin
    if (rst_n && done_irq) begin
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected completion", 1, 0);
      else begin
        mon_e = exp_q.pop_front();
        chk(rd_data == mon_e, "R3", "buffer at completion", rd_data, mon_e);
      end
    end
  end

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1;
    chk(rd_data == exp, req, "rd_data on read", rd_data, exp);
    @(negedge clk); rd_en = 1'b0;
    chk(buf_full == 1'b0, "R4", "buf_full after read", buf_full, 0);
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] peer,
                             input logic [7:0] exp_buf, input bit coll);
    logic [7:0] ptx, prx;
    int lat;
    exp_q.push_back(exp_buf);
    ptx = peer; prx = '0; lat = 0; sdi = peer[7];
    @(negedge clk); wr_en = 1'b1; wr_data = tx;
    @(negedge clk); wr_en = 1'b0;
    fork
      begin
        for (int k = 1; k <= 60; k++) begin
          @(negedge clk);
          if (done_irq) begin lat = k; break; end
        end
      end
      begin
        for (int b = 0; b < 8; b++) begin
          @(posedge sck_out); prx = {prx[6:0], sdo};
          @(negedge sck_out); ptx = {ptx[6:0], 1'b0}; sdi = ptx[7];
        end
      end
      begin
        if (coll) begin
          repeat (6) @(negedge clk);
          wr_en = 1'b1; wr_data = ~tx;
          @(negedge clk); wr_en = 1'b0;
        end
      end
    join
    chk(lat == 32, "R2", "cycles write to done_irq", lat, 32);
    chk(prx == tx, coll ? "R5" : "R1", "byte seen on SDO", prx, tx);
  endtask

  task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] exp_sdo,
                            input int nbits, input string req);
    logic [7:0] got;
    got = '0;
    ss_n_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdo_en == 1'b1, "R8", "sdo_en with select low", sdo_en, 1);
    for (int b = 0; b < nbits; b++) begin
      sdi = mtx[7-b];
      repeat (6) @(negedge clk);
      sck_in = 1'b1; got = {got[6:0], sdo};
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (6) @(negedge clk);
    if (nbits == 8) chk(got == exp_sdo, req, "slave byte on SDO", got, exp_sdo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; master = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    wr_data = '0; sck_in = 1'b0; ss_n_in = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!buf_full && !done_irq && !sck_out && !sdo_en && !wcol && !ovfl,
        "R7", "reset state", {buf_full, done_irq, sck_out, sdo_en, wcol, ovfl}, 0);
    enable = 1'b1;
    @(negedge clk);

    master_xfer(8'hA5, 8'h3C, 8'h3C, 1'b0);
    chk(buf_full == 1'b1, "R3", "buf_full after byte", buf_full, 1);
    do_read(8'h3C, "R4");
    master_xfer(8'h01, 8'h80, 8'h80, 1'b0);
    do_read(8'h80, "R1");

    master_xfer(8'h5A, 8'hC3, 8'hC3, 1'b1);
    chk(wcol == 1'b1, "R5", "wcol after busy write", wcol, 1);
    do_read(8'hC3, "R5");

    master_xfer(8'h11, 8'h22, 8'h22, 1'b0);
    chk(ovfl == 1'b0, "R6", "no overflow yet", ovfl, 0);
    master_xfer(8'h33, 8'h44, 8'h22, 1'b0);
    chk(ovfl == 1'b1, "R6", "ovfl after unread byte", ovfl, 1);
    chk(rd_data == 8'h22, "R6", "buffer kept", rd_data, 8'h22);
    chk(buf_full == 1'b1, "R6", "buf_full kept", buf_full, 1);

    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(!buf_full && !wcol && !ovfl && !sdo_en && !sck_out, "R7", "disabled state",
        {buf_full, wcol, ovfl, sdo_en, sck_out}, 0);
    wr_byte(8'hFF);
    enable = 1'b1;
    repeat (50) @(negedge clk);
    chk(buf_full == 1'b0 && sck_out == 1'b0, "R7", "write while disabled ignored",
        {buf_full, sck_out}, 0);

    enable = 1'b0; master = 1'b0;
    @(negedge clk); enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo_en == 1'b0, "R9", "slave SDO released while deselected", sdo_en, 0);
    wr_byte(8'h96);
    exp_q.push_back(8'h69);
    slave_xfer(8'h69, 8'h96, 8, "R8");
    do_read(8'h69, "R8");

    wr_byte(8'hF0);
    slave_xfer(8'hAA, 8'h00, 3, "R9");
    chk(sdo_en == 1'b0, "R9", "SDO released after abort", sdo_en, 0);
    chk(buf_full == 1'b0, "R9", "no completion after abort", buf_full, 0);
    wr_byte(8'h0F);
    exp_q.push_back(8'hC7);
    slave_xfer(8'hC7, 8'h0F, 8, "R9");
    do_read(8'hC7, "R9");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all expected completions seen", exp_q.size(), 0);
    summary();
  end
endmodule